// File: doc/BRIEF.md
# Dual CAM Slot Access Controller

This block sits between a simple byte-wide host register port and two common-interface conditional-access module slots. The host loads a 14-bit card address through two address registers. It picks the target slot and the address space (attribute memory or control/IO) in a control register. It then reads or writes the data register. That data access launches one timed byte transfer on the chosen slot's bus, with separate setup, strobe and hold phases. For a read, the fetched byte is returned to the host when the host-side ready rises again.

The control register also carries per-slot reset requests, per-slot transport-stream enables and the synchronised active-low card-detect status of both slots. A reset request is timed by the block and its bit drops back to zero on its own when the pulse ends. Any change of either card-detect input latches an interrupt flag. Reading the interrupt register reports the flag and clears it. The card link-layer protocol is handled above this block.

Register offsets on `host_addr`: 0 control, 1 address low, 2 address high, 3 data, 4 interrupt status. Other offsets read as zero.

Top module: `cam_slot_bridge`

## Requirements
- R1: After reset, `host_ready` is 1, `cam_ce_n`, `cam_rd_n` and `cam_wr_n` are inactive (high), `cam_rst`, `ts_en` and `irq` are 0, and the control register reads 8'h03 while both `cam_cd_n` inputs are high.
- R2: Address low register bits 7:1 drive card address bits 6:0, and its bit 0 is ignored and reads 0. Address high register bits 6:0 drive card address bits 13:7, and its bit 7 is ignored and reads 0. `cam_addr` holds {high[6:0], low[7:1]} for the whole access.
- R3: Control bit 7 selects the slot (0 or 1) and control bit 6 selects control/IO space (1) or attribute memory (0). During an access only the selected slot's `cam_ce_n` bit is low, and `cam_iosel` equals bit 6. Both bits read back as written.
- R4: A data access holds chip enable low for T_SETUP cycles before the strobe, holds the strobe low for T_STROBE cycles, and then keeps chip enable low for T_HOLD cycles. `host_ready` is low for exactly T_SETUP+T_STROBE+T_HOLD cycles after the accepted request.
- R5: A data read pulses only `cam_rd_n`, and the selected slot's input byte appears on `host_rdata` when `host_ready` returns high. A data write pulses only `cam_wr_n`, with the written byte on `cam_wdata`.
- R6: A host request made while `host_ready` is low is ignored and leaves the registers unchanged.
- R7: Writing 1 to control bit (5 - s) drives `cam_rst[s]` high for RST_CYCLES cycles. The bit reads 1 during that time and then clears by itself. Writing 0 to it does not stop a running reset.
- R8: Control bit (3 - s) drives `ts_en[s]` and reads back as written.
- R9: Control bit (1 - s) reads the synchronised `cam_cd_n[s]` (0 means a card is present). Writes to bits 1:0 have no effect.
- R10: A change of either `cam_cd_n` input sets `irq` high on the third clock edge after the change. Reading offset 4 returns 8'h01 while the flag is set, and that read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_ready | output | 1 | High when a new request can be taken |
| cam_addr | output | 14 | Card address |
| cam_wdata | output | 8 | Byte written to the card |
| cam_rdata_s0 | input | 8 | Byte from slot 0 |
| cam_rdata_s1 | input | 8 | Byte from slot 1 |
| cam_iosel | output | 1 | 1 control/IO space, 0 attribute memory |
| cam_ce_n | output | 2 | Active-low chip enable per slot |
| cam_rd_n | output | 1 | Active-low read strobe |
| cam_wr_n | output | 1 | Active-low write strobe |
| cam_rst | output | 2 | Per-slot card reset |
| cam_cd_n | input | 2 | Per-slot active-low card detect |
| ts_en | output | 2 | Per-slot transport-stream enable |
| irq | output | 1 | Card-detect change interrupt |

## Verification
The hardest case to reach is a host request that arrives while a card transfer is still running. It is meant to be dropped, and that is seen only by reading the register back later. The stimulus therefore issues an address-register write on the cycle right after a data read has been accepted. It waits for ready and then reads the register back. A second hard case is a running reset meeting a control write that carries a zero in its reset bit. The bench starts the other slot's reset with that write and counts both pulse lengths at the pins.

// File: rtl/cam_bridge_pkg.sv
`timescale 1ns/1ps
// Package: shared offsets, control-byte bit positions, phase type and
// the command record handed from the register file to the sequencer.
package cam_bridge_pkg;
    localparam int NSLOT   = 2;
    localparam int HOST_AW = 3;
    localparam int CAM_AW  = 14;
    localparam int BYTE_W  = 8;

    localparam logic [HOST_AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [HOST_AW-1:0] OFS_ALO  = 3'd1;
    localparam logic [HOST_AW-1:0] OFS_AHI  = 3'd2;
    localparam logic [HOST_AW-1:0] OFS_DATA = 3'd3;
    localparam logic [HOST_AW-1:0] OFS_IRQ  = 3'd4;

    // Control byte layout; per-slot fields sit at BASE - slot.
    localparam int CB_SLOT     = 7;
    localparam int CB_IOSEL    = 6;
    localparam int CB_RST_BASE = 5;
    localparam int CB_TS_BASE  = 3;
    localparam int CB_CD_BASE  = 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } cam_phase_e;

    typedef struct packed {
        logic              slot;
        logic              iosel;
        logic              rd;
        logic [CAM_AW-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } cam_cmd_t;
endpackage

// File: rtl/cam_slot_reset_timer.sv
`timescale 1ns/1ps
// Per-slot reset pulse timer.
// Does: a start pulse raises busy for RST_CYCLES cycles, then busy drops.
// Assumes: RST_CYCLES >= 1; a start while busy is ignored.
module cam_slot_reset_timer #(
    parameter int RST_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES + 1);

    logic [CW-1:0] remain;

    // Load the counter on start, count down while busy, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                remain <= CW'(RST_CYCLES - 1);
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/cam_card_detect.sv
`timescale 1ns/1ps
// Card-detect synchroniser and change interrupt.
// Does: double-flops the active-low detect inputs and latches a flag on
// any change of the synchronised value; ack clears the flag, set wins.
// Assumes: detect inputs are asynchronous and slow; reset value is "no card".
module cam_card_detect #(
    parameter int NS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] cd_n_in,
    input  logic          ack,
    output logic [NS-1:0] cd_sync_n,
    output logic          irq_flag
);
    logic [NS-1:0] meta_q;
    logic [NS-1:0] sync_q;
    logic [NS-1:0] prev_q;

    // Synchronise the inputs and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= cd_n_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Latch the change flag; a new change takes priority over the ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
        end else if (sync_q != prev_q) begin
            irq_flag <= 1'b1;
        end else if (ack) begin
            irq_flag <= 1'b0;
        end
    end

    assign cd_sync_n = sync_q;
endmodule

// File: rtl/cam_access_seq.sv
`timescale 1ns/1ps
// Card bus cycle sequencer.
// Does: runs one setup / strobe / hold transfer per start pulse on the
// slot named in the command and captures the read byte at strobe end.
// Assumes: start only while idle; all phase lengths >= 1.
module cam_access_seq
    import cam_bridge_pkg::*;
#(
    parameter int T_SETUP  = 2,
    parameter int T_STROBE = 3,
    parameter int T_HOLD   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cam_cmd_t          cmd_in,
    input  logic [BYTE_W-1:0] rdata_s0,
    input  logic [BYTE_W-1:0] rdata_s1,
    output logic              idle,
    output logic              read_done,
    output logic [BYTE_W-1:0] read_byte,
    output logic [CAM_AW-1:0] cam_addr,
    output logic [BYTE_W-1:0] cam_wdata,
    output logic              cam_iosel,
    output logic [NSLOT-1:0]  cam_ce_n,
    output logic              cam_rd_n,
    output logic              cam_wr_n
);
    localparam int TMAX01 = (T_SETUP > T_STROBE) ? T_SETUP : T_STROBE;
    localparam int TMAX   = (TMAX01 > T_HOLD) ? TMAX01 : T_HOLD;
    localparam int CW     = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

    cam_phase_e    phase;
    logic [CW-1:0] remain;
    cam_cmd_t      cmd_q;
    logic          last;
    logic [BYTE_W-1:0] slot_byte;

    assign last = (remain == '0);

    // Select the input byte of the slot being accessed.
    always_comb begin
        slot_byte = cmd_q.slot ? rdata_s1 : rdata_s0;
    end

    // Phase machine: latch the command, then walk setup, strobe, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            remain    <= '0;
            cmd_q     <= '0;
            read_byte <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        cmd_q  <= cmd_in;
                        phase  <= PH_SETUP;
                        remain <= CW'(T_SETUP - 1);
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase  <= PH_STROBE;
                        remain <= CW'(T_STROBE - 1);
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        if (cmd_q.rd) begin
                            read_byte <= slot_byte;
                        end
                        phase  <= PH_HOLD;
                        remain <= CW'(T_HOLD - 1);
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Drive the card bus from the phase and the latched command.
    always_comb begin
        idle      = (phase == PH_IDLE);
        read_done = (phase == PH_HOLD) && last && cmd_q.rd;
        cam_addr  = cmd_q.addr;
        cam_wdata = cmd_q.wdata;
        cam_iosel = cmd_q.iosel;
        cam_ce_n  = '1;
        if (phase != PH_IDLE) begin
            cam_ce_n[cmd_q.slot] = 1'b0;
        end
        cam_rd_n = !((phase == PH_STROBE) && cmd_q.rd);
        cam_wr_n = !((phase == PH_STROBE) && !cmd_q.rd);
    end
endmodule

// File: rtl/cam_host_regs.sv
`timescale 1ns/1ps
// Host-side register file.
// Does: decodes host requests, holds address/control fields, builds the
// transfer command, raises reset starts and the interrupt ack, and
// registers the read byte.
// Assumes: requests are taken only while the sequencer is idle.
module cam_host_regs
    import cam_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    input  logic               seq_idle,
    input  logic               read_done,
    input  logic [BYTE_W-1:0]  read_byte,
    input  logic [NSLOT-1:0]   rst_busy,
    input  logic [NSLOT-1:0]   cd_sync_n,
    input  logic               irq_flag,
    output logic [BYTE_W-1:0]  host_rdata,
    output cam_cmd_t           cmd,
    output logic               cmd_start,
    output logic [NSLOT-1:0]   rst_start,
    output logic [NSLOT-1:0]   ts_en,
    output logic               irq_ack
);
    localparam int HALF_AW = CAM_AW / 2;

    logic               accept;
    logic               wr_ctrl;
    logic [HALF_AW-1:0] alo_q;
    logic [HALF_AW-1:0] ahi_q;
    logic               slot_q;
    logic               iosel_q;
    logic [NSLOT-1:0]   ts_q;
    logic [BYTE_W-1:0]  ctrl_view;
    logic [BYTE_W-1:0]  rd_mux;

    // Decode a request that is actually taken.
    always_comb begin
        accept    = host_req && seq_idle;
        wr_ctrl   = accept && host_we && (host_addr == OFS_CTRL);
        cmd_start = accept && (host_addr == OFS_DATA);
        irq_ack   = accept && !host_we && (host_addr == OFS_IRQ);
        for (int s = 0; s < NSLOT; s++) begin
            rst_start[s] = wr_ctrl && host_wdata[CB_RST_BASE - s];
        end
    end

    // Store the writable fields of the address and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alo_q   <= '0;
            ahi_q   <= '0;
            slot_q  <= 1'b0;
            iosel_q <= 1'b0;
            ts_q    <= '0;
        end else if (accept && host_we) begin
            case (host_addr)
                OFS_CTRL: begin
                    slot_q  <= host_wdata[CB_SLOT];
                    iosel_q <= host_wdata[CB_IOSEL];
                    for (int s = 0; s < NSLOT; s++) begin
                        ts_q[s] <= host_wdata[CB_TS_BASE - s];
                    end
                end
                OFS_ALO: alo_q <= host_wdata[BYTE_W-1:1];
                OFS_AHI: ahi_q <= host_wdata[HALF_AW-1:0];
                default: ;
            endcase
        end
    end

    // Assemble the control byte as the host sees it.
    always_comb begin
        ctrl_view           = '0;
        ctrl_view[CB_SLOT]  = slot_q;
        ctrl_view[CB_IOSEL] = iosel_q;
        for (int s = 0; s < NSLOT; s++) begin
            ctrl_view[CB_RST_BASE - s] = rst_busy[s];
            ctrl_view[CB_TS_BASE - s]  = ts_q[s];
            ctrl_view[CB_CD_BASE - s]  = cd_sync_n[s];
        end
    end

    // Select the byte returned by a register read.
    always_comb begin
        case (host_addr)
            OFS_CTRL: rd_mux = ctrl_view;
            OFS_ALO:  rd_mux = {alo_q, 1'b0};
            OFS_AHI:  rd_mux = {1'b0, ahi_q};
            OFS_IRQ:  rd_mux = {{(BYTE_W-1){1'b0}}, irq_flag};
            default:  rd_mux = '0;
        endcase
    end

    // Register the read result: card byte at transfer end, else register view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (read_done) begin
            host_rdata <= read_byte;
        end else if (accept && !host_we && (host_addr != OFS_DATA)) begin
            host_rdata <= rd_mux;
        end
    end

    // Build the transfer command from the current register contents.
    always_comb begin
        cmd.slot  = slot_q;
        cmd.iosel = iosel_q;
        cmd.rd    = !host_we;
        cmd.addr  = {ahi_q, alo_q};
        cmd.wdata = host_wdata;
    end

    assign ts_en = ts_q;
endmodule

// File: rtl/cam_slot_bridge.sv
`timescale 1ns/1ps
// Top: dual CAM slot access controller.
// Does: ties the host register file, the card bus sequencer, one reset
// timer per slot and the card-detect interrupt logic together.
// Assumes: synchronous active-low reset; card-detect inputs asynchronous.
module cam_slot_bridge
    import cam_bridge_pkg::*;
#(
    parameter int T_SETUP    = 2,
    parameter int T_STROBE   = 3,
    parameter int T_HOLD     = 1,
    parameter int RST_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [2:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        host_ready,
    output logic [13:0] cam_addr,
    output logic [7:0]  cam_wdata,
    input  logic [7:0]  cam_rdata_s0,
    input  logic [7:0]  cam_rdata_s1,
    output logic        cam_iosel,
    output logic [1:0]  cam_ce_n,
    output logic        cam_rd_n,
    output logic        cam_wr_n,
    output logic [1:0]  cam_rst,
    input  logic [1:0]  cam_cd_n,
    output logic [1:0]  ts_en,
    output logic        irq
);
    cam_cmd_t          cmd;
    logic              cmd_start;
    logic              seq_idle;
    logic              read_done;
    logic [BYTE_W-1:0] read_byte;
    logic [NSLOT-1:0]  rst_start;
    logic [NSLOT-1:0]  cd_sync_n;
    logic              irq_ack;

    cam_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .seq_idle   (seq_idle),
        .read_done  (read_done),
        .read_byte  (read_byte),
        .rst_busy   (cam_rst),
        .cd_sync_n  (cd_sync_n),
        .irq_flag   (irq),
        .host_rdata (host_rdata),
        .cmd        (cmd),
        .cmd_start  (cmd_start),
        .rst_start  (rst_start),
        .ts_en      (ts_en),
        .irq_ack    (irq_ack)
    );

    cam_access_seq #(
        .T_SETUP  (T_SETUP),
        .T_STROBE (T_STROBE),
        .T_HOLD   (T_HOLD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_start),
        .cmd_in    (cmd),
        .rdata_s0  (cam_rdata_s0),
        .rdata_s1  (cam_rdata_s1),
        .idle      (seq_idle),
        .read_done (read_done),
        .read_byte (read_byte),
        .cam_addr  (cam_addr),
        .cam_wdata (cam_wdata),
        .cam_iosel (cam_iosel),
        .cam_ce_n  (cam_ce_n),
        .cam_rd_n  (cam_rd_n),
        .cam_wr_n  (cam_wr_n)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot_rst
        cam_slot_reset_timer #(
            .RST_CYCLES (RST_CYCLES)
        ) u_rst (
            .clk   (clk),
            .rst_n (rst_n),
            .start (rst_start[s]),
            .busy  (cam_rst[s])
        );
    end

    cam_card_detect #(
        .NS (NSLOT)
    ) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cd_n_in   (cam_cd_n),
        .ack       (irq_ack),
        .cd_sync_n (cd_sync_n),
        .irq_flag  (irq)
    );

    assign host_ready = seq_idle;
endmodule

// File: rtl/cam_slot_bridge_chk.sv
`timescale 1ns/1ps
// Checker: port-level protocol properties of the slot bridge, bound to the top.
module cam_slot_bridge_chk #(
    parameter int RST_CYCLES = 20
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic [2:0]  host_addr,
    input logic        host_ready,
    input logic [13:0] cam_addr,
    input logic [1:0]  cam_ce_n,
    input logic        cam_rd_n,
    input logic        cam_wr_n,
    input logic [1:0]  cam_rst,
    input logic [1:0]  cam_cd_n,
    input logic        irq
);
    // At most one slot enabled at a time.
    p_one_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cam_ce_n));

    // A strobe only occurs inside a chip-enabled window.
    p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cam_rd_n || !cam_wr_n) |-> (cam_ce_n != 2'b11));

    // Read and write strobes never overlap.
    p_excl_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cam_rd_n && !cam_wr_n));

    // An accepted data request makes the host side busy.
    p_busy_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && (host_addr == 3'd3)) |=> !host_ready);

    // The card address stays still while a transfer runs.
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && $past(!host_ready)) |-> $stable(cam_addr));

    // A detect change raises the interrupt three edges later.
    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cam_cd_n != $past(cam_cd_n)) |-> ##3 irq);

    for (genvar s = 0; s < 2; s++) begin : g_rst_len
        int run_len;

        // Count consecutive cycles with the slot reset high.
        always_ff @(posedge clk) begin
            if (!rst_n || !cam_rst[s]) begin
                run_len <= 0;
            end else begin
                run_len <= run_len + 1;
            end
        end

        // A reset pulse never outlasts its programmed length.
        p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cam_rst[s] |-> (run_len < RST_CYCLES));
    end
endmodule

bind cam_slot_bridge cam_slot_bridge_chk #(
    .RST_CYCLES (RST_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_addr  (host_addr),
    .host_ready (host_ready),
    .cam_addr   (cam_addr),
    .cam_ce_n   (cam_ce_n),
    .cam_rd_n   (cam_rd_n),
    .cam_wr_n   (cam_wr_n),
    .cam_rst    (cam_rst),
    .cam_cd_n   (cam_cd_n),
    .irq        (irq)
);

// File: tb/cam_slot_bridge_bench.sv
`timescale 1ns/1ps
// Directed bench for the dual CAM slot access controller.
module cam_slot_bridge_bench;
    localparam int TS   = 2;
    localparam int TSTB = 3;
    localparam int TH   = 1;
    localparam int RC   = 20;
    localparam int BUSY = TS + TSTB + TH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic [13:0] cam_addr;
    logic [7:0]  cam_wdata;
    logic [7:0]  cam_rdata_s0 = 8'hA5;
    logic [7:0]  cam_rdata_s1 = 8'h3C;
    logic        cam_iosel;
    logic [1:0]  cam_ce_n;
    logic        cam_rd_n;
    logic        cam_wr_n;
    logic [1:0]  cam_rst;
    logic [1:0]  cam_cd_n = 2'b11;
    logic [1:0]  ts_en;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int rst_cnt0 = 0;
    int rst_cnt1 = 0;

    // Results of the last card transfer as seen at the pins.
    int          o_busy, o_setup, o_strobe, o_other, o_gap;
    logic [13:0] o_addr;
    logic        o_iosel;
    logic [1:0]  o_ce;
    logic [7:0]  o_wd;
    logic [7:0]  o_rd;

    always #2.5 clk = ~clk;

    cam_slot_bridge #(
        .T_SETUP (TS), .T_STROBE (TSTB), .T_HOLD (TH), .RST_CYCLES (RC)
    ) u_cam_slot_bridge (
        .clk (clk), .rst_n (rst_n), .host_req (host_req), .host_we (host_we),
        .host_addr (host_addr), .host_wdata (host_wdata), .host_rdata (host_rdata),
        .host_ready (host_ready), .cam_addr (cam_addr), .cam_wdata (cam_wdata),
        .cam_rdata_s0 (cam_rdata_s0), .cam_rdata_s1 (cam_rdata_s1),
        .cam_iosel (cam_iosel), .cam_ce_n (cam_ce_n), .cam_rd_n (cam_rd_n),
        .cam_wr_n (cam_wr_n), .cam_rst (cam_rst), .cam_cd_n (cam_cd_n),
        .ts_en (ts_en), .irq (irq)
    );

    always @(negedge clk) begin
        if (cam_rst[0] === 1'b1) rst_cnt0++;
        if (cam_rst[1] === 1'b1) rst_cnt1++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        d = host_rdata;
    endtask

    // One data-register access, watching the card bus every cycle.
    task automatic cam_cycle(input logic we, input logic [7:0] wd);
        bit seen;
        logic strobe_now, other_now;
        seen = 0;
        o_busy = 0; o_setup = 0; o_strobe = 0; o_other = 0; o_gap = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = 3'd3; host_wdata = wd;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            host_req = 1'b0; host_we = 1'b0;
            if (host_ready) break;
            o_busy++;
            strobe_now = we ? !cam_wr_n : !cam_rd_n;
            other_now  = we ? !cam_rd_n : !cam_wr_n;
            if (cam_ce_n == 2'b11) o_gap++;
            if (other_now) o_other++;
            if (strobe_now) begin
                o_strobe++;
                if (!seen) begin
                    o_addr = cam_addr; o_iosel = cam_iosel; o_ce = cam_ce_n; o_wd = cam_wdata;
                end
                seen = 1;
            end else if (!seen && cam_ce_n != 2'b11) begin
                o_setup++;
            end
        end
        o_rd = host_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 ready", host_ready, 1);
        check("R1 ce_n", cam_ce_n, 2'b11);
        check("R1 strobes", {cam_rd_n, cam_wr_n}, 2'b11);
        check("R1 rst/ts/irq", {cam_rst, ts_en, irq}, 5'b0);
        reg_read(3'd0, d);
        check("R1 ctrl", d, 8'h03);
    endtask

    task automatic t_address;
        logic [7:0] d;
        reg_write(3'd1, 8'hB5);
        reg_write(3'd2, 8'hC3);
        reg_read(3'd1, d);
        check("R2 low readback", d, 8'hB4);
        reg_read(3'd2, d);
        check("R2 high readback", d, 8'h43);
    endtask

    task automatic t_read_io_slot0;
        reg_write(3'd0, 8'h40);
        cam_cycle(1'b0, 8'h00);
        check("R4 busy cycles", o_busy, BUSY);
        check("R4 setup cycles", o_setup, TS);
        check("R4 strobe cycles", o_strobe, TSTB);
        check("R4 ce held", o_gap, 0);
        check("R5 no write strobe", o_other, 0);
        check("R2 cam_addr", o_addr, 14'h21DA);
        check("R3 iosel", o_iosel, 1);
        check("R3 ce slot0", o_ce, 2'b10);
        check("R5 read byte slot0", o_rd, 8'hA5);
    endtask

    task automatic t_write_attr_slot1;
        reg_write(3'd1, 8'h02);
        reg_write(3'd2, 8'h7F);
        reg_write(3'd0, 8'h80);
        cam_cycle(1'b1, 8'h5C);
        check("R4 busy cycles wr", o_busy, BUSY);
        check("R4 strobe cycles wr", o_strobe, TSTB);
        check("R5 no read strobe", o_other, 0);
        check("R5 write byte", o_wd, 8'h5C);
        check("R2 cam_addr 2", o_addr, 14'h3F81);
        check("R3 attr space", o_iosel, 0);
        check("R3 ce slot1", o_ce, 2'b01);
    endtask

    task automatic t_read_slot1;
        logic [7:0] d;
        reg_write(3'd0, 8'hC0);
        reg_read(3'd0, d);
        check("R3 ctrl readback", d, 8'hC3);
        cam_cycle(1'b0, 8'h00);
        check("R3 ce slot1 rd", o_ce, 2'b01);
        check("R5 read byte slot1", o_rd, 8'h3C);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] d;
        reg_write(3'd1, 8'h10);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 3'd3;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 3'd1; host_wdata = 8'hEE;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (host_ready) break;
            @(negedge clk);
        end
        check("R6 read byte after ignore", host_rdata, 8'h3C);
        reg_read(3'd1, d);
        check("R6 low unchanged", d, 8'h10);
    endtask

    task automatic t_reset_pulse;
        logic [7:0] d;
        rst_cnt0 = 0; rst_cnt1 = 0;
        reg_write(3'd0, 8'h20);
        reg_read(3'd0, d);
        check("R7 bit5 busy", d, 8'h23);
        reg_write(3'd0, 8'h10);
        check("R7 both resets", cam_rst, 2'b11);
        for (int i = 0; i < 200; i++) begin
            if (cam_rst == 2'b00) break;
            @(negedge clk);
        end
        check("R7 slot0 length", rst_cnt0, RC);
        check("R7 slot1 length", rst_cnt1, RC);
        reg_read(3'd0, d);
        check("R7 self clear", d, 8'h03);
    endtask

    task automatic t_stream_enable;
        logic [7:0] d;
        reg_write(3'd0, 8'h08);
        check("R8 ts slot0", ts_en, 2'b01);
        reg_read(3'd0, d);
        check("R8 ctrl 08", d, 8'h0B);
        reg_write(3'd0, 8'h04);
        check("R8 ts slot1", ts_en, 2'b10);
        reg_read(3'd0, d);
        check("R8 ctrl 04", d, 8'h07);
    endtask

    task automatic t_card_detect;
        logic [7:0] d;
        @(negedge clk);
        cam_cdn_set(2'b10);
        @(negedge clk);
        check("R10 irq edge1", irq, 0);
        @(negedge clk);
        check("R10 irq edge2", irq, 0);
        @(negedge clk);
        check("R10 irq edge3", irq, 1);
        reg_read(3'd0, d);
        check("R9 slot0 present", d, 8'h05);
        reg_write(3'd0, 8'h06);
        reg_read(3'd0, d);
        check("R9 cd bits not writable", d, 8'h05);
        reg_read(3'd4, d);
        check("R10 irq status", d, 8'h01);
        check("R10 irq cleared", irq, 0);
        reg_read(3'd4, d);
        check("R10 irq status clear", d, 8'h00);
        cam_cdn_set(2'b00);
        repeat (4) @(negedge clk);
        check("R10 irq slot1", irq, 1);
        reg_read(3'd0, d);
        check("R9 both present", d, 8'h04);
        reg_read(3'd4, d);
        check("R10 irq status 2", d, 8'h01);
    endtask

    task automatic cam_cdn_set(input logic [1:0] v);
        cam_cd_n = v;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_address();
        t_read_io_slot0();
        t_write_attr_slot1();
        t_read_slot1();
        t_busy_ignore();
        t_reset_pulse();
        t_stream_enable();
        t_card_detect();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule